// File: doc/BRIEF.md
# Class-D Bridge Output Controller

This block is the digital stage between a pulse-width modulator and the two output legs of a bridge-tied class-D power stage. Each carrier period it takes one duty-cycle sample and drives the positive leg high for that many carrier ticks. The negative leg gets the complement. Each leg has its own output-enable, and driving the enable low puts that leg into high impedance.

Four conditions override normal modulation. An active-low standby input parks the block in a low-power idle state. A supply-undervoltage flag stops the carrier and floats both legs. Three short-circuit flags latch a fault that turns the drivers off for a programmable hold-off and then releases them automatically. An active-low mute input replaces the modulated waveform with a fixed 50% square wave. Changes of the softer modes are deferred to a carrier-period boundary, so no leg ever emits a truncated pulse.

Top module: `bridgeDriveCtrl`

## Requirements
- R1: While the synchronized `standbyN` is low, both enables and both drives are low and the carrier counter is held at zero.
- R2: In mute, the positive leg is high during the first half of each carrier period (counter MSB = 0) and low in the second half, giving exactly 2^(CNT_W-1) high ticks per period. The negative leg is its complement, and both enables are high.
- R3: When `uvFlag` is high, both enables and both drives are low from the next clock on and the carrier is held at zero. When the flag clears, operation resumes.
- R4: A high level on any of `shortBridge`, `shortPosGnd` or `shortNegGnd` sets `faultActive` and turns both drivers off (enables and drives low) on the next clock.
- R5: The fault clears by itself after HOLD_CYC consecutive clocks with no short flag. Output resumes at the following carrier wrap.
- R6: In normal operation, the positive leg is high exactly while the carrier counter is below the latched duty value, so a duty of D gives D high ticks out of 2^CNT_W. The negative leg is the complement, and both enables are high. The duty sample is latched when the counter wraps.
- R7: `standbyN` and `muteN` each pass through a two-flop synchronizer. Held high, they are inactive and the block modulates normally.
- R8: Priority, highest first: undervoltage, standby, short fault, mute, normal modulation.
- R9: Undervoltage and short faults take effect on the next clock. Changes between modulation, mute and entry to standby take effect only at a carrier wrap.
- R10: A short flag seen while the fault is already active restarts the hold-off count from zero.
- R11: While standby is asserted the fault latch is cleared. Short flags are ignored during standby and during undervoltage.
- R12: While `rstN` is low, all outputs are low and the block starts in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dutyIn | input | CNT_W | Duty sample from the modulator |
| standbyN | input | 1 | Active-low standby request (asynchronous) |
| muteN | input | 1 | Active-low mute request (asynchronous) |
| uvFlag | input | 1 | Supply undervoltage, synchronous |
| shortBridge | input | 1 | Short between the two legs, synchronous |
| shortPosGnd | input | 1 | Positive leg shorted to ground, synchronous |
| shortNegGnd | input | 1 | Negative leg shorted to ground, synchronous |
| posDrive | output | 1 | Positive leg drive level |
| negDrive | output | 1 | Negative leg drive level |
| posEn | output | 1 | Positive leg enable (low = high impedance) |
| negEn | output | 1 | Negative leg enable (low = high impedance) |
| faultActive | output | 1 | Short-protection hold-off in progress |

## Verification
The assertions assume that `uvFlag`, the three short flags and `dutyIn` are already synchronous to `clk`, and that only `standbyN` and `muteN` may arrive asynchronously. The bench changes every input just after a falling edge, so each input is settled well before the next rising edge. It holds the duty value constant across any measured carrier period. Pulse-width results are taken as counts of high ticks over a full period after at least two wraps, so they do not depend on the carrier phase.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_STBY,
    MODE_FAULT,
    MODE_MUTE,
    MODE_RUN
  } mode_e;

  typedef struct packed {
    logic runCarrier;
    logic loadDuty;
    logic squareSel;
    logic driveOn;
  } strobe_t;
endpackage

// File: rtl/bdcControl.sv
module bdcControl
  import bdc_pkg::*;
#(
  parameter int HOLD_CYC = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    standbyN,
  input  logic    muteN,
  input  logic    uvFlag,
  input  logic    shortBridge,
  input  logic    shortPosGnd,
  input  logic    shortNegGnd,
  input  logic    wrap,
  output strobe_t strb,
  output logic    faultActive
);
  localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

  logic [1:0] stbySh, muteSh;
  logic stbySync, muteSync, anyShort, faultQ, protect, idle;
  logic [HOLD_W-1:0] holdCnt;
  mode_e modeQ, reqMode;

  // two-flop synchronizers; reset value means "asserted" (safe idle)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbySh <= 2'b00;
      muteSh <= 2'b00;
    end else begin
      stbySh <= {stbySh[0], standbyN};
      muteSh <= {muteSh[0], muteN};
    end
  end
  assign stbySync = stbySh[1];
  assign muteSync = muteSh[1];
  assign anyShort = shortBridge | shortPosGnd | shortNegGnd;

  // fault latch and hold-off timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultQ  <= 1'b0;
      holdCnt <= '0;
    end else if (!stbySync) begin
      faultQ  <= 1'b0;
      holdCnt <= '0;
    end else if (uvFlag) begin
      faultQ  <= faultQ;
      holdCnt <= holdCnt;
    end else if (anyShort) begin
      faultQ  <= 1'b1;
      holdCnt <= '0;
    end else if (faultQ) begin
      if (holdCnt == HOLD_LAST) begin
        faultQ  <= 1'b0;
        holdCnt <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end
  assign faultActive = faultQ;

  // requested mode by priority
  always_comb begin
    if (uvFlag)                 reqMode = MODE_OFF;
    else if (!stbySync)         reqMode = MODE_STBY;
    else if (faultQ | anyShort) reqMode = MODE_FAULT;
    else if (!muteSync)         reqMode = MODE_MUTE;
    else                        reqMode = MODE_RUN;
  end

  assign protect = (reqMode == MODE_OFF) || (reqMode == MODE_FAULT);
  assign idle    = (modeQ == MODE_OFF) || (modeQ == MODE_STBY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       modeQ <= MODE_STBY;
    else if (protect || idle || wrap) modeQ <= reqMode;
  end

  always_comb begin
    strb.runCarrier = !idle;
    strb.loadDuty   = wrap || idle;
    strb.squareSel  = (modeQ == MODE_MUTE);
    strb.driveOn    = (modeQ == MODE_MUTE) || (modeQ == MODE_RUN);
  end

  p_hiz_under_uv_r3: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |=> (!strb.driveOn && !strb.runCarrier));

  p_short_trips_r4: assert property (@(posedge clk) disable iff (!rstN)
    (anyShort && !uvFlag && stbySync) |=> (faultActive && !strb.driveOn));

  p_retrigger_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive && anyShort && !uvFlag && stbySync) |=> faultActive);

  p_stby_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stbySync |=> !faultActive);
endmodule

// File: rtl/bdcDatapath.sv
module bdcDatapath
  import bdc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] dutyIn,
  input  strobe_t          strb,
  output logic             wrap,
  output logic             posDrive,
  output logic             negDrive,
  output logic             posEn,
  output logic             negEn
);
  logic [CNT_W-1:0] cnt, dutyReg;
  logic pwmBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (!strb.runCarrier) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dutyReg <= '0;
    else if (strb.loadDuty) dutyReg <= dutyIn;
  end

  assign wrap     = strb.runCarrier && (cnt == '1);
  assign pwmBit   = strb.squareSel ? ~cnt[CNT_W-1] : (cnt < dutyReg);
  assign posDrive = strb.driveOn & pwmBit;
  assign negDrive = strb.driveOn & ~pwmBit;
  assign posEn    = strb.driveOn;
  assign negEn    = strb.driveOn;

  p_idle_counter_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.runCarrier |=> (cnt == '0));

  p_square_boundary_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.driveOn && $past(strb.driveOn) && (strb.squareSel != $past(strb.squareSel)))
      |-> (cnt == '0));
endmodule

// File: rtl/bridgeDriveCtrl.sv
module bridgeDriveCtrl
  import bdc_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 625_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic             standbyN,
  input  logic             muteN,
  input  logic             uvFlag,
  input  logic             shortBridge,
  input  logic             shortPosGnd,
  input  logic             shortNegGnd,
  output logic             posDrive,
  output logic             negDrive,
  output logic             posEn,
  output logic             negEn,
  output logic             faultActive
);
  strobe_t strb;
  logic wrap;

  bdcControl #(.HOLD_CYC(HOLD_CYC)) uCtl (
    .clk(clk), .rstN(rstN), .standbyN(standbyN), .muteN(muteN),
    .uvFlag(uvFlag), .shortBridge(shortBridge), .shortPosGnd(shortPosGnd),
    .shortNegGnd(shortNegGnd), .wrap(wrap), .strb(strb),
    .faultActive(faultActive)
  );

  bdcDatapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .dutyIn(dutyIn), .strb(strb), .wrap(wrap),
    .posDrive(posDrive), .negDrive(negDrive), .posEn(posEn), .negEn(negEn)
  );
endmodule

// File: tb/tb_bridgeDriveCtrl.sv
module tb_bridgeDriveCtrl;
  localparam int CNT_W  = 4;
  localparam int HOLD   = 40;
  localparam int PERIOD = 1 << CNT_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic [CNT_W-1:0] dutyIn = '0;
  logic standbyN = 1'b1, muteN = 1'b1, uvFlag = 1'b0;
  logic shortBridge = 1'b0, shortPosGnd = 1'b0, shortNegGnd = 1'b0;
  logic posDrive, negDrive, posEn, negEn, faultActive;

  bridgeDriveCtrl #(.CNT_W(CNT_W), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rstN(rstN), .dutyIn(dutyIn), .standbyN(standbyN),
    .muteN(muteN), .uvFlag(uvFlag), .shortBridge(shortBridge),
    .shortPosGnd(shortPosGnd), .shortNegGnd(shortNegGnd),
    .posDrive(posDrive), .negDrive(negDrive), .posEn(posEn),
    .negEn(negEn), .faultActive(faultActive)
  );

  always #4 clk = ~clk;

  // kind 0: snapshot {posDrive,negDrive,posEn,negEn,faultActive}
  // kind 1: high ticks of posDrive over one period (-1 if complement broken)
  typedef struct {
    string tag;
    int    kind;
    int    expVal;
  } item_t;

  item_t q[$];
  int nChecks = 0, nFails = 0;
  bit busy = 1'b0;
  bit done = 1'b0;

  task automatic push(input string tag, input int kind, input int expVal);
    item_t it;
    it.tag = tag; it.kind = kind; it.expVal = expVal;
    busy = 1'b1;
    q.push_back(it);
    wait (!busy);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor
  initial begin
    item_t it;
    int act;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      act = 0;
      if (it.kind == 0) begin
        #1;
        act = int'({posDrive, negDrive, posEn, negEn, faultActive});
      end else begin
        for (int i = 0; i < PERIOD; i++) begin
          #1;
          if (!posEn || !negEn || (posDrive == negDrive)) act = -1000;
          if (posDrive) act++;
          @(negedge clk);
        end
        if (act < 0) act = -1;
      end
      nChecks++;
      if (act != it.expVal) begin
        nFails++;
        $display("FAIL %s actual=%0d expected=%0d", it.tag, act, it.expVal);
      end
      busy = 1'b0;
    end
  end

  // watchdog
  initial begin
    #(200_000 * 8);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // driver
  initial begin
    dutyIn = 4'd5;
    ticks(3);
    push("R12 reset outputs low", 0, 0);
    rstN = 1'b1;

    ticks(40);
    push("R6 R7 duty 5 inputs tied high", 1, 5);
    dutyIn = 4'd0;  ticks(40);
    push("R6 duty 0", 1, 0);
    dutyIn = 4'd15; ticks(40);
    push("R6 duty max", 1, 15);
    dutyIn = 4'd9;  ticks(40);
    push("R6 duty 9", 1, 9);

    muteN = 1'b0; dutyIn = 4'd3; ticks(40);
    push("R2 mute square 50pct", 1, PERIOD / 2);
    standbyN = 1'b0; ticks(40);
    push("R1 R8 standby over mute", 0, 0);
    standbyN = 1'b1; muteN = 1'b1; dutyIn = 4'd9; ticks(40);
    push("R1 resume after standby", 1, 9);

    uvFlag = 1'b1; ticks(1);
    push("R3 R9 undervoltage next clock", 0, 0);
    shortBridge = 1'b1; ticks(3); shortBridge = 1'b0; ticks(2);
    push("R8 R11 short ignored under undervoltage", 0, 0);
    uvFlag = 1'b0; ticks(40);
    push("R3 resume after undervoltage", 1, 9);

    shortPosGnd = 1'b1; ticks(1); shortPosGnd = 1'b0;
    push("R4 R9 short trips next clock", 0, 1);
    ticks(19);
    push("R5 fault held during hold-off", 0, 1);
    ticks(10);
    shortBridge = 1'b1; ticks(1); shortBridge = 1'b0;
    ticks(30);
    push("R10 retrigger restarts hold-off", 0, 1);
    ticks(40);
    push("R5 auto resume after hold-off", 1, 9);

    muteN = 1'b0; ticks(40);
    shortNegGnd = 1'b1; ticks(1); shortNegGnd = 1'b0;
    push("R4 R8 neg short overrides mute", 0, 1);
    standbyN = 1'b0; ticks(10);
    push("R11 standby clears fault", 0, 0);
    shortPosGnd = 1'b1; ticks(2); shortPosGnd = 1'b0; ticks(2);
    push("R11 short ignored in standby", 0, 0);
    standbyN = 1'b1; muteN = 1'b1; ticks(40);
    push("R11 run after standby release", 1, 9);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule